// File: doc/BRIEF.md
# Horizontal Blanking and Display-Enable Generator

This block generates the horizontal timing of one scanline and advances once per character clock. A character counter runs from zero up to a programmed line total and then wraps. Two outputs come from that count: a horizontal blank window and an active-display enable. Before the display enable leaves the block, it passes through a delay line that software can set.

Software sets the timing through an indexed write/read port: one index selects a register and one data byte goes with it. The block finds the end of blanking with a partial-width match. Only the low 6 counter bits (standard mode) or the low 8 bits (extended mode) are compared against an end value. That end value is assembled from fields held in three different registers. Software programs it as the low bits of blank start plus blank length. Because of this, a blank window may run past the line wrap and still end correctly.

Top module: `hblank_de_gen`

## Requirements
- R1: A synchronous reset clears the counter, the blank state, the delay line and all registers. In the cycle after reset, `hblank`, `disp_en` and `hcount` are all 0.
- R2: The port has these registers. Index 00h is line total. Index 01h is display end. Index 02h is blank start. Index 05h is the sync-end byte; bit 7 is blank-end bit 5. Index 09h is mode/skew: bit 0 is mode, bits 2:1 are skew, and it reads back as {5'b0, skew, mode}. Index 3Ch is the extended end register; bits 7:6 are blank-end bits 7:6, and it reads back as {bits, 6'b0}. Every one of these reads back what was written. Any other index reads 0, and writes to it have no effect. A write is used from the next character clock on.
- R3: `hcount` counts up by one each clock. It goes to 0 on the clock after it equals the line total.
- R4: `hblank` rises on the clock after `hcount` equals blank start. It stays low while no start match occurs.
- R5: In standard mode (mode bit 0), the end value is {sync-end bit 7, index 03h bits 4:0}. `hblank` falls on the clock after the first cycle in which `hcount[5:0]` equals this end value. This also applies after the counter has wrapped into the next line.
- R6: In extended mode (mode bit 1), the end value is 8 bits wide. Index 3Ch bits 7:6 sit above the 6 standard bits. The end value is compared against `hcount[7:0]`.
- R7: The undelayed enable is (`hcount` < display end), registered once. `disp_en` is that signal delayed by skew clocks: 0, 1, 2 or 3.
- R8: Index 03h bits 4:0 hold the low end bits. On a read, bit 7 always returns 1 and bits 6:5 return 0, whatever was written.
- R9: If a start match and an end match happen in the same cycle, the start match wins and blank stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_index | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_index` (combinational) |
| hcount | output | 8 | Horizontal character counter |
| hblank | output | 1 | Horizontal blank |
| disp_en | output | 1 | Skewed display enable |

## Verification
The assertions assume that reset is held for at least two clocks before it is released. This ensures the registers and the counter are cleared together. The assertions also assume the counter never sits above the line total. The stimulus always sets the line total above the running count, or changes it only on a wrap where the count is small. Start and end values always lie inside the line. In every scenario, a start match occurs before an end match is expected. Skew is changed only between runs of whole lines, and the scoreboard checks every cycle, including the cycle right after each change.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
    localparam int CNT_W       = 8;
    localparam int REG_W       = 8;
    localparam int IDX_W       = 8;
    localparam int LO_W        = 5;
    localparam int STD_END_W   = 6;
    localparam int EXT_END_W   = 8;
    localparam int SKEW_STAGES = 3;
    localparam int SKEW_W      = $clog2(SKEW_STAGES + 1);

    typedef enum logic [IDX_W-1:0] {
        IX_TOTAL   = 8'h00,
        IX_DEND    = 8'h01,
        IX_BSTART  = 8'h02,
        IX_BEND    = 8'h03,
        IX_SYNCEND = 8'h05,
        IX_MODE    = 8'h09,
        IX_EXTEND  = 8'h3C
    } hbg_idx_e;

    typedef struct packed {
        logic [CNT_W-1:0]                 htotal;
        logic [CNT_W-1:0]                 disp_end;
        logic [CNT_W-1:0]                 hb_start;
        logic [LO_W-1:0]                  end_lo;
        logic                             end_b5;
        logic [EXT_END_W-STD_END_W-1:0]   end_hi;
        logic                             ext_mode;
        logic [SKEW_W-1:0]                skew;
    } hbg_cfg_t;

    // Gather the blank-end value from its three register sources.
    function automatic logic [EXT_END_W-1:0] blank_end_value(hbg_cfg_t c);
        logic [EXT_END_W-STD_END_W-1:0] hi;
        hi = c.ext_mode ? c.end_hi : '0;
        return {hi, c.end_b5, c.end_lo};
    endfunction
endpackage

// File: rtl/hbg_regs.sv
`timescale 1ns/1ps
module hbg_regs
    import hbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] index,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output hbg_cfg_t         cfg
);
    hbg_cfg_t         cfg_q;
    logic [REG_W-2:0] sync_rest_q;   // sync-end bits not used by this block

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            sync_rest_q <= '0;
        end else if (we) begin
            case (index)
                IX_TOTAL:   cfg_q.htotal   <= wdata[CNT_W-1:0];
                IX_DEND:    cfg_q.disp_end <= wdata[CNT_W-1:0];
                IX_BSTART:  cfg_q.hb_start <= wdata[CNT_W-1:0];
                IX_BEND:    cfg_q.end_lo   <= wdata[LO_W-1:0];
                IX_SYNCEND: begin
                    cfg_q.end_b5 <= wdata[REG_W-1];
                    sync_rest_q  <= wdata[REG_W-2:0];
                end
                IX_MODE: begin
                    cfg_q.ext_mode <= wdata[0];
                    cfg_q.skew     <= wdata[SKEW_W:1];
                end
                IX_EXTEND:  cfg_q.end_hi <= wdata[REG_W-1:STD_END_W];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (index)
            IX_TOTAL:   rdata = REG_W'(cfg_q.htotal);
            IX_DEND:    rdata = REG_W'(cfg_q.disp_end);
            IX_BSTART:  rdata = REG_W'(cfg_q.hb_start);
            IX_BEND:    rdata = {1'b1, {(REG_W-LO_W-1){1'b0}}, cfg_q.end_lo};
            IX_SYNCEND: rdata = {cfg_q.end_b5, sync_rest_q};
            IX_MODE:    rdata = REG_W'({cfg_q.skew, cfg_q.ext_mode});
            IX_EXTEND:  rdata = {cfg_q.end_hi, {STD_END_W{1'b0}}};
            default:    rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/hbg_line_ctr.sv
`timescale 1ns/1ps
module hbg_line_ctr
    import hbg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     htotal,
    input  logic [CNT_W-1:0]     hb_start,
    input  logic [CNT_W-1:0]     disp_end,
    input  logic [EXT_END_W-1:0] end_val,
    input  logic                 ext_mode,
    output logic [CNT_W-1:0]     hcount,
    output logic                 hblank,
    output logic                 de_raw
);
    logic end_hit;
    logic start_hit;

    // Partial-width end match: only the low 6 or 8 counter bits take part.
    always_comb begin
        if (ext_mode)
            end_hit = (hcount[EXT_END_W-1:0] == end_val);
        else
            end_hit = (hcount[STD_END_W-1:0] == end_val[STD_END_W-1:0]);
    end

    assign start_hit = (hcount == hb_start);
    assign de_raw    = (hcount < disp_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcount <= '0;
            hblank <= 1'b0;
        end else begin
            hcount <= (hcount == htotal) ? '0 : CNT_W'(hcount + 1'b1);
            if (start_hit)
                hblank <= 1'b1;
            else if (hblank && end_hit)
                hblank <= 1'b0;
        end
    end
endmodule

// File: rtl/hbg_skew_pipe.sv
`timescale 1ns/1ps
module hbg_skew_pipe
    import hbg_pkg::*;
#(
    parameter int STAGES = SKEW_STAGES,
    localparam int SEL_W = $clog2(STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_in,
    input  logic [SEL_W-1:0] skew,
    output logic             de_out
);
    logic [STAGES:0] tap;

    always_ff @(posedge clk) begin
        if (rst) tap[0] <= 1'b0;
        else     tap[0] <= de_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tap[i] <= 1'b0;
            else     tap[i] <= tap[i-1];
        end
    end

    assign de_out = tap[skew];
endmodule

// File: rtl/hblank_de_gen.sv
`timescale 1ns/1ps
module hblank_de_gen
    import hbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_index,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [CNT_W-1:0] hcount,
    output logic             hblank,
    output logic             disp_en
);
    hbg_cfg_t             cfg_s;
    logic [EXT_END_W-1:0] end_val;
    logic                 de_raw;

    hbg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .index (cfg_index),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_s)
    );

    assign end_val = blank_end_value(cfg_s);

    hbg_line_ctr u_line (
        .clk      (clk),
        .rst      (rst),
        .htotal   (cfg_s.htotal),
        .hb_start (cfg_s.hb_start),
        .disp_end (cfg_s.disp_end),
        .end_val  (end_val),
        .ext_mode (cfg_s.ext_mode),
        .hcount   (hcount),
        .hblank   (hblank),
        .de_raw   (de_raw)
    );

    hbg_skew_pipe #(.STAGES(SKEW_STAGES)) u_skew (
        .clk    (clk),
        .rst    (rst),
        .de_in  (de_raw),
        .skew   (cfg_s.skew),
        .de_out (disp_en)
    );
endmodule

// File: rtl/hbg_checker.sv
`timescale 1ns/1ps
module hbg_checker
    import hbg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  hcount,
    input logic              hblank,
    input logic              disp_en,
    input logic [CNT_W-1:0]  htotal,
    input logic [CNT_W-1:0]  hb_start,
    input logic [CNT_W-1:0]  disp_end,
    input logic [SKEW_W-1:0] skew
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!hblank && !disp_en && hcount == '0));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (hcount == htotal) |=> (hcount == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (hcount != htotal) |=> (hcount == CNT_W'($past(hcount) + 1'b1)));

    assert_blank_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (hcount == hb_start) |=> hblank);

    assert_blank_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!hblank && hcount != hb_start) |=> !hblank);

    assert_no_skew_R7: assert property (@(posedge clk) disable iff (rst)
        (skew == '0 && $past(!rst)) |-> (disp_en == $past(hcount < disp_end)));
endmodule

bind hblank_de_gen hbg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .hcount   (hcount),
    .hblank   (hblank),
    .disp_en  (disp_en),
    .htotal   (cfg_s.htotal),
    .hb_start (cfg_s.hb_start),
    .disp_end (cfg_s.disp_end),
    .skew     (cfg_s.skew)
);

// File: tb/sim_hblank_de_gen.sv
`timescale 1ns/1ps
module sim_hblank_de_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_index = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [7:0] hcount;
    logic       hblank;
    logic       disp_en;

    hblank_de_gen u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_index(cfg_index),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .hcount(hcount), .hblank(hblank), .disp_en(disp_en)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "R1";
    logic [9:0] exp_q[$];
    string      tag_q[$];

    // Reference state built from the requirements
    logic [7:0] m_total, m_dend, m_bstart, m_sync, m_cnt;
    logic [4:0] m_lo;
    logic [1:0] m_ext, m_skew;
    logic       m_mode, m_blank;
    logic [3:0] m_tap;

    task automatic model_edge();
        logic [7:0] ev;
        logic       hit;
        if (rst) begin
            m_total = 0; m_dend = 0; m_bstart = 0; m_sync = 0; m_cnt = 0;
            m_lo = 0; m_ext = 0; m_skew = 0; m_mode = 0; m_blank = 0; m_tap = 0;
        end else begin
            ev  = {(m_mode ? m_ext : 2'b00), m_sync[7], m_lo};
            hit = m_mode ? (m_cnt == ev) : (m_cnt[5:0] == ev[5:0]);
            if (m_cnt == m_bstart)   m_blank = 1'b1;
            else if (m_blank && hit) m_blank = 1'b0;
            m_tap = {m_tap[2:0], (m_cnt < m_dend)};
            m_cnt = (m_cnt == m_total) ? 8'd0 : m_cnt + 8'd1;
            if (cfg_we) begin
                case (cfg_index)
                    8'h00: m_total  = cfg_wdata;
                    8'h01: m_dend   = cfg_wdata;
                    8'h02: m_bstart = cfg_wdata;
                    8'h03: m_lo     = cfg_wdata[4:0];
                    8'h05: m_sync   = cfg_wdata;
                    8'h09: begin m_mode = cfg_wdata[0]; m_skew = cfg_wdata[2:1]; end
                    8'h3C: m_ext    = cfg_wdata[7:6];
                    default: ;
                endcase
            end
        end
    endtask

    // Driver: advance one character clock and queue the expected outputs
    task automatic tick();
        @(posedge clk);
        model_edge();
        exp_q.push_back({m_blank, m_tap[m_skew], m_cnt});
        tag_q.push_back(cur_tag);
        #1;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        cfg_we = 1'b1; cfg_index = idx; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        cfg_index = idx;
        #0.5;
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_err++;
            $display("FAIL %s: read idx %h got %h expected %h", tag, idx, cfg_rdata, exp);
        end
    endtask

    // Monitor: compare the design against the queue between edges
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if ({hblank, disp_en, hcount} !== e) begin
                n_err++;
                $display("FAIL %s: got hb=%b de=%b cnt=%0d expected hb=%b de=%b cnt=%0d",
                         t, hblank, disp_en, hcount, e[9], e[8], e[7:0]);
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #100000;
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete, got hung expected done");
        report();
    end

    initial begin
        // R1 reset state
        rst = 1'b1; cur_tag = "R1";
        run(3);
        rst = 1'b0;

        // R2 setup and readback; standard 4-clock blank 14..18
        cur_tag = "R2";
        wr(8'h00, 8'd19); wr(8'h01, 8'd12); wr(8'h02, 8'd14);
        wr(8'h03, 8'd18); wr(8'h05, 8'h00); wr(8'h09, 8'h00);
        rd_check(8'h00, 8'd19, "R2"); rd_check(8'h01, 8'd12, "R2");
        rd_check(8'h02, 8'd14, "R2"); rd_check(8'h05, 8'h00, "R2");
        rd_check(8'h09, 8'h00, "R2");
        cur_tag = "R3/R4/R5";
        run(45);

        // R7 skew 1..3
        for (int k = 1; k <= 3; k++) begin
            wr(8'h09, 8'(k << 1));
            rd_check(8'h09, 8'(k << 1), "R2");
            cur_tag = "R7";
            run(25);
        end
        wr(8'h09, 8'h00);

        // R5 blank window crossing the wrap: start 17, end match at count 2
        cur_tag = "R5";
        wr(8'h02, 8'd17); wr(8'h03, 8'd2);
        run(45);

        // R5 partial compare: start 60, end value 6 matches at count 70
        wr(8'h00, 8'd100); wr(8'h02, 8'd60); wr(8'h03, 8'd6);
        run(210);

        // R6 extended: start 150, end 0xFA (ext=11, b5=1, lo=1A)
        cur_tag = "R6";
        wr(8'h00, 8'd255); wr(8'h02, 8'd150); wr(8'h03, 8'h1A);
        wr(8'h05, 8'h80); wr(8'h3C, 8'hC0); wr(8'h09, 8'h01);
        rd_check(8'h3C, 8'hC0, "R2"); rd_check(8'h05, 8'h80, "R2");
        run(520);

        // R5 same fields in standard mode: end at count 186
        cur_tag = "R5";
        wr(8'h09, 8'h00);
        run(300);

        // R9 start and end coincide: blank never drops
        cur_tag = "R9";
        wr(8'h00, 8'd19); wr(8'h02, 8'd5); wr(8'h03, 8'd5); wr(8'h05, 8'h00);
        run(50);

        // R8 fixed bits of the blank-end register
        cur_tag = "R8";
        wr(8'h03, 8'h00);
        rd_check(8'h03, 8'h80, "R8");
        wr(8'h03, 8'hFF);
        rd_check(8'h03, 8'h9F, "R8");

        // R2 unimplemented index
        cur_tag = "R2";
        wr(8'h44, 8'hAA);
        rd_check(8'h44, 8'h00, "R2");
        run(5);

        // R1 reset in mid-line
        cur_tag = "R1";
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(3);

        @(negedge clk);
        #1;
        report();
    end
endmodule